// File: doc/BRIEF.md
# Interleaved Banked Byte Memory

This block presents a 32K-byte, byte-addressable storage space built from sixteen 2K-byte banks held inside the block. One request port takes a 15-bit byte address, a write flag and a write byte. A build-time parameter decides which address bits pick the bank. With the upper bits as bank select, neighbouring bytes share a bank. With the lower bits as bank select, neighbouring bytes fall in different banks.

After a bank takes a request, it stays busy for a fixed number of cycles. A new request aimed at a busy bank holds `req_ready` low until that bank is free again. Requests aimed at other banks are accepted in the next cycle. A sequential stream therefore runs at one byte per cycle under low-order selection and at one byte per busy window under high-order selection. Each read answers one cycle after acceptance with a valid strobe. A write gives no answer.

Top module: `ilv_bank_mem`

## Requirements
- R1: With `LOW_ORDER`=0, address bits 14..11 give the bank number and bits 10..0 give the byte offset inside that bank.
- R2: With `LOW_ORDER`=1, address bits 3..0 give the bank number and bits 14..4 give the byte offset inside that bank.
- R3: `bank_en` bit i is high only for bank i, and only in a cycle where a request is accepted (`req_valid` and `req_ready` both high). In every other cycle `bank_en` is all zeros, so at most one bit is ever set.
- R4: A read accepted at a clock edge raises `rsp_valid` for the cycle after that edge. In that cycle `rsp_rdata` holds the byte most recently written to the same 15-bit address. Read answers come back in the order the reads were accepted.
- R5: A bank that accepts a request at edge e cannot accept again before edge e+`BANK_LAT`. `req_ready` is low exactly when the bank addressed by `req_addr` is inside that window.
- R6: An accepted write produces no `rsp_valid` pulse.
- R7: After reset, every bank is free, so `req_ready` is high. `rsp_valid` is low, and `bank_en` is zero while `req_valid` is low.
- R8: A read burst to four consecutive addresses, starting with every bank free, is accepted over 4 consecutive edges with `LOW_ORDER`=1. With `LOW_ORDER`=0 the first and last acceptances are 3·`BANK_LAT` edges apart.
- R9: Back-to-back requests to two different banks are both accepted on consecutive edges, with no stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present |
| req_write | input | 1 | 1 means write, 0 means read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | The addressed bank can accept this cycle |
| bank_en | output | 16 | One-hot enable of the bank that accepts this cycle |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |

## Verification
Two instances are built, one for each interleaving choice. Both are driven with random addresses mixed with runs of consecutive addresses, and every read answer is compared with a flat 32K-byte model. Consecutive addresses are the pattern that tells the two bank mappings apart: they hit a new bank on every access under one mapping and the same bank under the other. Because of this, the stall cycles the bench predicts for each access, and the burst span it expects, differ between the two instances. Random addresses mostly exercise the offset split and data integrity. Directed pairs to distinct banks, together with a burst after an idle gap, pin down the exact number of stall cycles at the edge of the busy window.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int ILV_ADDR_W = 15;
    localparam int ILV_BANK_W = 4;
    localparam int ILV_DATA_W = 8;
    localparam int ILV_LAT    = 4;

    typedef enum logic {ILV_HIGH_ORDER = 1'b0, ILV_LOW_ORDER = 1'b1} ilv_mode_e;

    function automatic int ilv_cnt_w(input int lat);
        return (lat < 2) ? 1 : $clog2(lat + 1);
    endfunction
endpackage

// File: rtl/ilv_addr_split.sv
module ilv_addr_split #(
    parameter int ADDR_W    = 15,
    parameter int BANK_W    = 4,
    parameter bit LOW_ORDER = 1'b1,
    localparam int OFF_W    = ADDR_W - BANK_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BANK_W-1:0] bank_o,
    output logic [OFF_W-1:0]  off_o
);
    generate
        if (LOW_ORDER) begin : g_low
            assign bank_o = addr_i[BANK_W-1:0];
            assign off_o  = addr_i[ADDR_W-1:BANK_W];
        end else begin : g_high
            assign bank_o = addr_i[ADDR_W-1:OFF_W];
            assign off_o  = addr_i[OFF_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ilv_bank_decode.sv
module ilv_bank_decode #(
    parameter int BANK_W   = 4,
    localparam int NBANK   = 1 << BANK_W
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic              go_i,
    output logic [NBANK-1:0]  en_o
);
    always_comb begin
        en_o = '0;
        for (int i = 0; i < NBANK; i++) begin
            if (go_i && (bank_i == BANK_W'(i))) en_o[i] = 1'b1;
        end
    end
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int OFF_W  = 11,
    parameter int DATA_W = 8,
    parameter int LAT    = 4,
    localparam int DEPTH = 1 << OFF_W,
    localparam int CW    = ilv_pkg::ilv_cnt_w(LAT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [CW-1:0]     cnt_q;

    always_ff @(posedge clk) begin
        if (sel_i) begin
            if (we_i) mem[off_i] <= wdata_i;
            else      rdata_o    <= mem[off_i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             cnt_q <= '0;
        else if (sel_i)      cnt_q <= CW'(LAT - 1);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        sel_i |-> !busy_o); // R5

    generate
        if (LAT > 1) begin : g_busy_chk
            AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
                sel_i |=> busy_o); // R5
        end
    endgenerate
endmodule

// File: rtl/ilv_bank_mem.sv
module ilv_bank_mem #(
    parameter int ADDR_W    = ilv_pkg::ILV_ADDR_W,
    parameter int BANK_W    = ilv_pkg::ILV_BANK_W,
    parameter int DATA_W    = ilv_pkg::ILV_DATA_W,
    parameter int BANK_LAT  = ilv_pkg::ILV_LAT,
    parameter bit LOW_ORDER = 1'b1,
    localparam int NBANK    = 1 << BANK_W,
    localparam int OFF_W    = ADDR_W - BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [NBANK-1:0]  bank_en,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [BANK_W-1:0] bank;
    logic [OFF_W-1:0]  off;
    logic [NBANK-1:0]  busy;
    logic [DATA_W-1:0] bank_rd [NBANK];
    logic [BANK_W-1:0] rd_bank_q;
    logic              accept;

    ilv_addr_split #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .LOW_ORDER(LOW_ORDER)) u_split (
        .addr_i(req_addr), .bank_o(bank), .off_o(off));

    assign req_ready = !busy[bank];
    assign accept    = req_valid && req_ready;

    ilv_bank_decode #(.BANK_W(BANK_W)) u_dec (
        .bank_i(bank), .go_i(accept), .en_o(bank_en));

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            ilv_bank #(.OFF_W(OFF_W), .DATA_W(DATA_W), .LAT(BANK_LAT)) u_bank (
                .clk(clk), .rst(rst), .sel_i(bank_en[b]), .we_i(req_write),
                .off_i(off), .wdata_i(req_wdata), .rdata_o(bank_rd[b]),
                .busy_o(busy[b]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rd_bank_q <= '0;
        end else begin
            rsp_valid <= accept && !req_write;
            if (accept && !req_write) rd_bank_q <= bank;
        end
    end

    assign rsp_rdata = bank_rd[rd_bank_q];

    AST_ONEHOT_EN: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_en)); // R3
    AST_EN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (bank_en == '0)); // R3
    AST_READ_RSP: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_write) |=> rsp_valid); // R4
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_write) |=> !rsp_valid); // R6
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!rsp_valid && req_ready)); // R7
endmodule

// File: tb/ilv_bank_mem_bench.sv
module ilv_bank_mem_bench;
    localparam int PERIOD = 10;
    localparam int LAT    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [14:0] req_addr  = '0;
    logic [7:0]  req_wdata = '0;
    logic        sel = 1'b0;
    logic        ready_lo, ready_hi, rspv_lo, rspv_hi;
    logic [15:0] en_lo, en_hi;
    logic [7:0]  rd_lo, rd_hi;

    always #(PERIOD/2) clk = ~clk;

    ilv_bank_mem #(.BANK_LAT(LAT), .LOW_ORDER(1'b1)) u_ilv_bank_mem (
        .clk(clk), .rst(rst), .req_valid(req_valid && !sel), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(ready_lo),
        .bank_en(en_lo), .rsp_valid(rspv_lo), .rsp_rdata(rd_lo));

    ilv_bank_mem #(.BANK_LAT(LAT), .LOW_ORDER(1'b0)) u_ilv_bank_mem_hi (
        .clk(clk), .rst(rst), .req_valid(req_valid && sel), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(ready_hi),
        .bank_en(en_hi), .rsp_valid(rspv_hi), .rsp_rdata(rd_hi));

    int  checks = 0, errors = 0, cyc = 0;
    bit  done = 0;
    logic [7:0] ref_mem [2][32768];
    bit         known [2][32768];
    int  free_at [2][16];
    bit  pend [2];
    bit  pend_known [2];
    logic [7:0] pend_val [2];
    int  last_acc;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [3:0] bank_of(bit hi, logic [14:0] a);
        return hi ? a[14:11] : a[3:0];   // R1 high-order, R2 low-order
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // at a falling edge: check the answer slots of both instances
    task automatic check_rsp();
        for (int m = 0; m < 2; m++) begin
            logic v = m ? rspv_hi : rspv_lo;
            logic [7:0] d = m ? rd_hi : rd_lo;
            if (pend[m]) begin
                check(v === 1'b1, "R4 rsp_valid", v, 1);
                if (pend_known[m]) check(d === pend_val[m], "R4 rdata", d, pend_val[m]);
            end else begin
                check(v === 1'b0, "R6 no rsp", v, 0);
            end
            pend[m] = 0;
        end
    endtask

    task automatic issue(bit w, logic [14:0] a, logic [7:0] d, output int waits);
        int m = sel;
        logic [3:0] b = bank_of(sel, a);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        waits = 0;
        forever begin
            logic rdy;
            logic [15:0] en;
            #1;
            rdy = sel ? ready_hi : ready_lo;
            en  = sel ? en_hi : en_lo;
            check(rdy === (cyc >= free_at[m][b]), "R5 ready", rdy, cyc >= free_at[m][b]);
            check(en === (rdy ? (16'h1 << b) : 16'h0), "R3 bank_en", en, rdy ? (16'h1 << b) : 0);
            if (rdy) break;
            @(posedge clk); @(negedge clk);
            check_rsp();
            waits++;
            if (waits > 50) break;
        end
        last_acc = cyc;
        free_at[m][b] = cyc + LAT;
        @(posedge clk);
        if (w) begin
            ref_mem[m][a] = d; known[m][a] = 1;
        end else begin
            pend[m] = 1; pend_known[m] = known[m][a]; pend_val[m] = ref_mem[m][a];
        end
        @(negedge clk);
        req_valid = 0;
        check_rsp();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            check_rsp();
        end
    endtask

    initial begin
        int w0, first, span_lo, span_hi;
        logic [14:0] a;
        void'($urandom(32'd2024));
        for (int m = 0; m < 2; m++) for (int b = 0; b < 16; b++) free_at[m][b] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R7 reset state
        #1;
        check(ready_lo === 1'b1 && ready_hi === 1'b1, "R7 ready", {ready_hi, ready_lo}, 3);
        check(rspv_lo === 1'b0 && rspv_hi === 1'b0, "R7 rsp_valid", {rspv_hi, rspv_lo}, 0);
        check(en_lo === 16'h0 && en_hi === 16'h0, "R7 bank_en", {en_hi, en_lo}, 0);
        @(negedge clk);

        // R1 / R2 directed offset split: distinct bytes that share a bank offset in one map only
        for (int m = 0; m < 2; m++) begin
            sel = m[0];
            issue(1, 15'h0000, 8'hA1, w0);
            issue(1, 15'h0800, 8'hB2, w0);
            issue(1, 15'h0010, 8'hC3, w0);
            issue(1, 15'h7FFF, 8'hD4, w0);
            issue(0, 15'h0000, 0, w0);
            issue(0, 15'h0800, 0, w0);
            issue(0, 15'h0010, 0, w0);
            issue(0, 15'h7FFF, 0, w0);
        end

        // R9 two different banks back to back
        idle(LAT);
        sel = 0;
        issue(1, 15'h0100, 8'h11, w0);
        issue(1, 15'h0101, 8'h22, w0);
        check(w0 == 0, "R9 low-order no stall", w0, 0);
        sel = 1;
        issue(1, 15'h0100, 8'h33, w0);
        issue(1, 15'h0900, 8'h44, w0);
        check(w0 == 0, "R9 high-order no stall", w0, 0);

        // random mix with sequential runs
        a = '0;
        for (int i = 0; i < 1500; i++) begin
            sel = $urandom % 2;
            if ($urandom % 2) a = a + 1'b1; else a = 15'($urandom);
            issue(($urandom % 3) != 0, a, 8'($urandom), w0);
            if ($urandom % 8 == 0) idle($urandom % 4);
        end

        // R8 sequential read bursts
        idle(LAT + 1);
        sel = 0;
        issue(0, 15'h0200, 0, w0); first = last_acc;
        for (int k = 1; k < 4; k++) issue(0, 15'h0200 + 15'(k), 0, w0);
        span_lo = last_acc - first;
        check(span_lo == 3, "R8 low-order span", span_lo, 3);
        idle(LAT + 1);
        sel = 1;
        issue(0, 15'h0200, 0, w0); first = last_acc;
        for (int k = 1; k < 4; k++) issue(0, 15'h0200 + 15'(k), 0, w0);
        span_hi = last_acc - first;
        check(span_hi == 3 * LAT, "R8 high-order span", span_hi, 3 * LAT);
        check(span_lo < span_hi, "R8 low faster", span_lo, span_hi);

        idle(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule